// File: doc/BRIEF.md
# Keyed-load programmable interrupt timer

This block is a cartridge-side interrupt timer programmed by CPU writes. A write lands on the block when the top four address bits select the 0xC000 page. Address bits 2:0 then pick one of eight registers, and all other address bits are ignored. The timer is built from a prescaler and an 8-bit main counter. The prescaler is normally 8 bits wide, and 12 bits when selected. Values written to the two counters are first XORed with a key register that software programs. Three event inputs can clock the timer: a CPU cycle tick, a PPU address edge and a scanline tick. A mode register picks one of them, sets the count direction, and can widen or halt the prescaler.

Each selected event steps the prescaler. Each prescaler wrap steps the main counter. If the main counter wraps while the timer is enabled, the block raises `irq_o`. The line stays high until software writes register 0 with bit 0 clear. Generating the event pulses and decoding the rest of the mapper are done elsewhere.

Top module: `irq_xor_timer`

## Requirements
- R1: After reset, `irq_o` is low, the timer is disabled, mode is 0 (counting halted), the key is 0, and the prescaler and main counter are 0.
- R2: Only a write whose `addr_i[15:12]` equals 0xC has an effect. Within that page only `addr_i[2:0]` selects the register, so 0xCF0D acts as offset 5.
- R3: Offset 6 stores the key. Offset 4 loads the low 8 prescaler bits with data XOR key and clears the upper 4 bits. Offset 5 loads the main counter with data XOR key.
- R4: Mode bits 1:0 select the event source. 0 selects `cpu_tick_i`, 1 selects `ppu_edge_i`, 2 selects `line_tick_i`, and 3 selects no source. Unselected inputs have no effect.
- R5: Mode bits 7:6 set the direction. 1 counts up and 2 counts down. 0 or 3 holds both counters.
- R6: Each selected event steps the prescaler by one in the chosen direction. A prescaler wrap (all ones to 0 counting up, 0 to all ones counting down) steps the main counter once in the same direction.
- R7: Mode bit 3 clear gives an 8-bit prescaler, and the offset-7 value is then ignored. Mode bit 3 set with offset 7 holding 0xFF gives a 12-bit prescaler. Mode bit 3 set with any other offset-7 value halts counting.
- R8: A main-counter wrap (0xFF to 0x00 up, 0x00 to 0xFF down) raises `irq_o` at the same clock edge as the causing event, but only while enabled. A wrap while disabled leaves `irq_o` low.
- R9: Offset 3 enables the timer. Offset 0 writes data bit 0 to the enable, and a clear bit 0 also drops `irq_o` at that edge. Otherwise `irq_o` stays high once raised.
- R10: A counter load written in the same cycle as an event wins over the step of that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data |
| cpu_tick_i | input | 1 | One pulse per CPU cycle |
| ppu_edge_i | input | 1 | One pulse per PPU address edge |
| line_tick_i | input | 1 | One pulse per scanline |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A sweep runs every source against both directions. Each run uses prescaler loads at 0x00, 0x7F and 0xFF and a different key, and counts the events up to the interrupt. The count is 1 at one end and 256 at the other, so an off-by-one in the wrap points, a swapped direction or a missing XOR changes it. With the wide prescaler the counts become 4096 and 4102, which tells the 12-bit period from the 8-bit one. Further runs feed the unselected sources, the halting direction codes, the halting size value and disabled wraps, and these must leave the line low. A write made in the same cycle as an event shows whether the load or the step wins. Aliased and out-of-page addresses show the decode.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;
  localparam int DW = 8;

  localparam logic [2:0] OFF_ENA  = 3'd0;
  localparam logic [2:0] OFF_MODE = 3'd1;
  localparam logic [2:0] OFF_ARM  = 3'd3;
  localparam logic [2:0] OFF_PLD  = 3'd4;
  localparam logic [2:0] OFF_MLD  = 3'd5;
  localparam logic [2:0] OFF_KEY  = 3'd6;
  localparam logic [2:0] OFF_PSZ  = 3'd7;

  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_PPU  = 2'd1,
    SRC_LINE = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    DIR_HOLD0 = 2'd0,
    DIR_UP    = 2'd1,
    DIR_DOWN  = 2'd2,
    DIR_HOLD3 = 2'd3
  } dir_e;

  typedef struct packed {
    dir_e       dir;
    logic [1:0] spare_hi;
    logic       psz_adj;
    logic       spare_lo;
    src_e       src;
  } mode_t;

  localparam logic [DW-1:0] PSZ_WIDE = 8'hFF;
endpackage

// File: rtl/irq_tmr_regs.sv
module irq_tmr_regs
  import irq_tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    off_i,
  input  logic [DW-1:0] data_i,
  output mode_t         mode_o,
  output logic [DW-1:0] key_o,
  output logic [DW-1:0] psz_o,
  output logic          en_o,
  output logic          ack_o,
  output logic          ld_pre_o,
  output logic          ld_main_o,
  output logic [DW-1:0] ld_val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      key_o  <= '0;
      psz_o  <= '0;
      en_o   <= 1'b0;
    end else if (wr_i) begin
      case (off_i)
        OFF_ENA:  en_o   <= data_i[0];
        OFF_ARM:  en_o   <= 1'b1;
        OFF_MODE: mode_o <= mode_t'(data_i);
        OFF_KEY:  key_o  <= data_i;
        OFF_PSZ:  psz_o  <= data_i;
        default:  ;
      endcase
    end
  end

  assign ld_val_o  = data_i ^ key_o;
  assign ld_pre_o  = wr_i && (off_i == OFF_PLD);
  assign ld_main_o = wr_i && (off_i == OFF_MLD);
  assign ack_o     = wr_i && (off_i == OFF_ENA) && !data_i[0];
endmodule

// File: rtl/irq_tmr_stepper.sv
module irq_tmr_stepper #(
  parameter int W      = 12,
  parameter int NARROW = 8,
  parameter int LDW    = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [LDW-1:0] load_val_i,
  input  logic           step_i,
  input  logic           up_i,
  input  logic           wide_i,
  output logic [W-1:0]   q_o,
  output logic           wrap_o
);
  localparam logic [W-1:0] NMASK = W'((64'd1 << NARROW) - 64'd1);

  logic [W-1:0] mask, cur, nxt_act, nxt;

  always_comb begin
    mask    = wide_i ? '1 : NMASK;
    cur     = q_o & mask;
    nxt_act = up_i ? cur + W'(1) : cur - W'(1);
    nxt     = (q_o & ~mask) | (nxt_act & mask);
    wrap_o  = up_i ? (cur == mask) : (cur == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= W'(load_val_i);
    else if (step_i)  q_o <= nxt;
  end
endmodule

// File: rtl/irq_xor_timer.sv
module irq_xor_timer
  import irq_tmr_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [3:0]  PAGE   = 4'hC,
  parameter int          WIDE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              cpu_tick_i,
  input  logic              ppu_edge_i,
  input  logic              line_tick_i,
  output logic              irq_o
);
  localparam int PRE_W = WIDE_W;

  logic          hit;
  mode_t         mode_q;
  logic [DW-1:0] key_q, psz_q, ld_val;
  logic          en_q, ack, ld_pre, ld_main;
  logic          evt, run, up, wide;
  logic          step_pre, step_main, pre_wrap, main_wrap;
  logic [PRE_W-1:0] pre_q;
  logic [DW-1:0]    main_q;
  logic          unused_bits;

  assign hit = wr_en_i && (addr_i[ADDR_W-1 -: 4] == PAGE);
  assign unused_bits = ^{addr_i[ADDR_W-5:3], mode_q.spare_hi, mode_q.spare_lo};

  irq_tmr_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (hit),
    .off_i     (addr_i[2:0]),
    .data_i    (data_i),
    .mode_o    (mode_q),
    .key_o     (key_q),
    .psz_o     (psz_q),
    .en_o      (en_q),
    .ack_o     (ack),
    .ld_pre_o  (ld_pre),
    .ld_main_o (ld_main),
    .ld_val_o  (ld_val)
  );

  always_comb begin
    unique case (mode_q.src)
      SRC_CPU:  evt = cpu_tick_i;
      SRC_PPU:  evt = ppu_edge_i;
      SRC_LINE: evt = line_tick_i;
      default:  evt = 1'b0;
    endcase
  end

  // counting runs only for a valid direction and, with size adjust, only at the wide code
  assign up   = (mode_q.dir == DIR_UP);
  assign wide = mode_q.psz_adj && (psz_q == PSZ_WIDE);
  assign run  = ((mode_q.dir == DIR_UP) || (mode_q.dir == DIR_DOWN))
                && (!mode_q.psz_adj || wide);

  assign step_pre  = evt && run;
  assign step_main = step_pre && pre_wrap;

  irq_tmr_stepper #(.W(PRE_W), .NARROW(DW), .LDW(DW)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_pre),
    .load_val_i (ld_val),
    .step_i     (step_pre),
    .up_i       (up),
    .wide_i     (wide),
    .q_o        (pre_q),
    .wrap_o     (pre_wrap)
  );

  irq_tmr_stepper #(.W(DW), .NARROW(DW), .LDW(DW)) u_main (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_main),
    .load_val_i (ld_val),
    .step_i     (step_main),
    .up_i       (up),
    .wide_i     (1'b1),
    .q_o        (main_q),
    .wrap_o     (main_wrap)
  );

  // a load on the main counter suppresses its wrap this cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   irq_o <= 1'b0;
    else if (ack)                                  irq_o <= 1'b0;
    else if (step_main && main_wrap && en_q && !ld_main) irq_o <= 1'b1;
  end
endmodule

// File: rtl/irq_tmr_chk.sv
module irq_tmr_chk #(
  parameter int ADDR_W = 16,
  parameter int PRE_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        data_i,
  input logic              irq_o,
  input logic [7:0]        key_q,
  input logic [7:0]        mode_q,
  input logic [PRE_W-1:0]  pre_q,
  input logic [7:0]        main_q
);
  logic hit, clr;
  assign hit = wr_en_i && (addr_i[ADDR_W-1 -: 4] == 4'hC);
  assign clr = hit && (addr_i[2:0] == 3'd0) && !data_i[0];

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !irq_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr |=> irq_o);

  a_r3_pre_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && (addr_i[2:0] == 3'd4) |=> pre_q == PRE_W'($past(data_i ^ key_q)));

  a_r3_main_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && (addr_i[2:0] == 3'd5) |=> main_q == $past(data_i ^ key_q));

  a_r5_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit && (mode_q[7:6] != 2'd1) && (mode_q[7:6] != 2'd2)
    |=> $stable(main_q) && $stable(pre_q));

  a_r2_off_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(key_q) && $stable(mode_q));
endmodule

bind irq_xor_timer irq_tmr_chk #(.ADDR_W(ADDR_W), .PRE_W(WIDE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .data_i  (data_i),
  .irq_o   (irq_o),
  .key_q   (key_q),
  .mode_q  (mode_q),
  .pre_q   (pre_q),
  .main_q  (main_q)
);

// File: tb/sim_irq_xor_timer.sv
`timescale 1ns/1ps
module sim_irq_xor_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [2:0]  ev = '0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_xor_timer u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .addr_i      (addr),
    .data_i      (data),
    .cpu_tick_i  (ev[0]),
    .ppu_edge_i  (ev[1]),
    .line_tick_i (ev[2]),
    .irq_o       (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: irq act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; addr = '0; data = '0;
  endtask

  task automatic pulse(input logic [2:0] msk, input int n);
    for (int i = 0; i < n; i++) begin
      ev = msk;
      @(posedge clk); #1;
    end
    ev = '0;
  endtask

  // effective values p, m are written as raw = value ^ key
  task automatic cfg(input logic [7:0] key, input logic [7:0] p, input logic [7:0] m,
                     input logic [7:0] mode, input logic [7:0] psz);
    wr(16'hC000, 8'h00);
    wr(16'hC006, key);
    wr(16'hC004, p ^ key);
    wr(16'hC005, m ^ key);
    wr(16'hC007, psz);
    wr(16'hC001, mode);
  endtask

  task automatic run_case(input logic [2:0] msk, input int n, input string req);
    if (n > 1) pulse(msk, n - 1);
    chk(irq == 1'b0, req, irq, 0);
    pulse(msk, 1);
    chk(irq == 1'b1, req, irq, 1);
  endtask

  function automatic int events_to_irq(input bit up, input int p, input int m, input int per);
    if (up) return (per - p) + (255 - m) * per;
    return (p + 1) + m * per;
  endfunction

  initial begin
    #20; rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(irq == 1'b0, "R1 reset irq", irq, 0);
    wr(16'hC003, 8'h00);
    pulse(3'b111, 20);
    chk(irq == 1'b0, "R1 mode 0 halts", irq, 0);
    wr(16'hC001, 8'h80);
    pulse(3'b001, 1);
    chk(irq == 1'b1, "R1 counters zero (down wraps at once)", irq, 1);

    // R6 R4 R5 R3 sweep: every source, both directions, three prescaler loads
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int pi = 0; pi < 3; pi++) begin
          int p, m, n;
          logic [7:0] key;
          p   = (pi == 0) ? 8'h00 : (pi == 1) ? 8'h7F : 8'hFF;
          m   = d ? 8'h00 : 8'hFF;
          key = 8'(s * 8'h31 + pi * 8'h0C + d + 1);
          n   = events_to_irq(d == 0, p, m, 256);
          cfg(key, 8'(p), 8'(m), (d ? 8'h80 : 8'h40) | 8'(s), 8'hFF); // R7 size ignored w/o bit 3
          wr(16'hC003, 8'h00);
          run_case(3'b001 << s, n, "R6 sweep");
        end
      end
    end

    // R6 two-stage count with keyed loads
    cfg(8'h5A, 8'hF0, 8'hFE, 8'h40, 8'h00);
    wr(16'hC003, 8'h00);
    run_case(3'b001, events_to_irq(1, 8'hF0, 8'hFE, 256), "R6 up two stage");
    cfg(8'h33, 8'h10, 8'h01, 8'h81, 8'h00);
    wr(16'hC003, 8'h00);
    run_case(3'b010, events_to_irq(0, 8'h10, 8'h01, 256), "R6 down two stage");

    // R4 unselected sources and source code 3
    cfg(8'h00, 8'hFF, 8'hFF, 8'h42, 8'h00);
    wr(16'hC003, 8'h00);
    pulse(3'b011, 20);
    chk(irq == 1'b0, "R4 unselected ignored", irq, 0);
    pulse(3'b100, 1);
    chk(irq == 1'b1, "R4 line source", irq, 1);
    cfg(8'h00, 8'hFF, 8'hFF, 8'h43, 8'h00);
    wr(16'hC003, 8'h00);
    pulse(3'b111, 20);
    chk(irq == 1'b0, "R4 source 3 counts nothing", irq, 0);

    // R5 halting direction codes
    cfg(8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00);
    wr(16'hC003, 8'h00);
    pulse(3'b001, 20);
    chk(irq == 1'b0, "R5 dir 0 halts", irq, 0);
    wr(16'hC001, 8'hC0);
    pulse(3'b001, 20);
    chk(irq == 1'b0, "R5 dir 3 halts", irq, 0);
    wr(16'hC001, 8'h40);
    pulse(3'b001, 1);
    chk(irq == 1'b1, "R5 up resumes from held value", irq, 1);

    // R7 wide prescaler and halting size code
    cfg(8'h00, 8'h00, 8'hFF, 8'h48, 8'hFF);
    wr(16'hC003, 8'h00);
    run_case(3'b001, events_to_irq(1, 0, 8'hFF, 4096), "R7 wide up");
    cfg(8'h21, 8'h05, 8'h01, 8'h88, 8'hFF);
    wr(16'hC003, 8'h00);
    run_case(3'b001, events_to_irq(0, 5, 1, 4096), "R7 wide down");
    cfg(8'h00, 8'h00, 8'h00, 8'h88, 8'h12);
    wr(16'hC003, 8'h00);
    pulse(3'b001, 10);
    chk(irq == 1'b0, "R7 other size halts", irq, 0);

    // R8 wrap while disabled; R9 enable via offset 0, hold and clear
    cfg(8'h00, 8'hFF, 8'hFF, 8'h40, 8'h00);
    pulse(3'b001, 1);
    chk(irq == 1'b0, "R8 disabled wrap", irq, 0);
    wr(16'hC004, 8'hFF);
    wr(16'hC005, 8'hFF);
    wr(16'hC000, 8'h01);
    pulse(3'b001, 1);
    chk(irq == 1'b1, "R8 enabled wrap", irq, 1);
    pulse(3'b001, 3);
    chk(irq == 1'b1, "R9 held over events", irq, 1);
    wr(16'hC003, 8'h00);
    wr(16'hC000, 8'h01);
    chk(irq == 1'b1, "R9 held over enable writes", irq, 1);
    wr(16'hC000, 8'h00);
    chk(irq == 1'b0, "R9 clear on bit0 low", irq, 0);

    // R2 decode: off-page writes ignored, aliased in-page offset accepted
    cfg(8'h00, 8'hFF, 8'hFE, 8'h40, 8'h00);
    wr(16'hC003, 8'h00);
    wr(16'hD005, 8'h00);
    wr(16'h8005, 8'h00);
    wr(16'hB006, 8'h77);
    run_case(3'b001, events_to_irq(1, 8'hFF, 8'hFE, 256), "R2 off page ignored");
    cfg(8'h00, 8'hFF, 8'h00, 8'h40, 8'h00);
    wr(16'hCF0D, 8'hFE);
    wr(16'hCF0B, 8'h00);
    run_case(3'b001, events_to_irq(1, 8'hFF, 8'hFE, 256), "R2 alias offset");

    // R10 load beats step in the same cycle
    cfg(8'h00, 8'hFF, 8'hFF, 8'h40, 8'h00);
    wr(16'hC003, 8'h00);
    wr_en = 1'b1; addr = 16'hC005; data = 8'hFE; ev = 3'b001;
    @(posedge clk); #1;
    wr_en = 1'b0; addr = '0; data = '0; ev = '0;
    chk(irq == 1'b0, "R10 load wins, no wrap", irq, 0);
    run_case(3'b001, 512, "R10 count from loaded value");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule